// File: doc/BRIEF.md
# CPU clock, reset and ready generator

This block turns one fast master oscillator into the timing signals a processor subsystem needs. A mode input picks the processor clock: a slow setting that divides the master clock by six and keeps the output high for one third of the period, or a fast setting that divides by four with equal high and low times. A timer clock at one twenty-fourth of the master rate and an oscillator output at half the master rate run alongside and do not depend on the mode.

The block also takes two asynchronous active-low requests. A reset request forces two reset outputs high at once and releases them in step with the processor clock. A wait request holds the processor READY output false for as long as the line is low. READY comes back only after a rising and then a falling processor clock edge have both seen the line high.

All logic runs on the master clock. Processor clock edges are carried inside the block as one-cycle enables, so no logic is clocked by a derived clock.

Top module: `cpu_timing_gen`

## Requirements
- R1: With `fast_sel_i` low, `cpu_clk_o` repeats every 6 master cycles: high for 2 cycles, then low for 4.
- R2: With `fast_sel_i` high, `cpu_clk_o` repeats every 4 master cycles: high for 2 cycles, then low for 2.
- R3: `fast_sel_i` is sampled only on the master edge where `cpu_clk_o` falls. The low time that follows that edge, and the whole period after it, use the sampled mode, so no shortened pulse appears.
- R4: `timer_clk_o` divides the master clock by 24, high for 12 cycles and low for 12, whatever the mode.
- R5: `osc_half_o` toggles on every master edge once the internal reset has been released.
- R6: `cpu_rst_o` and `bus_rst_o` go high as soon as `rst_req_n_i` goes low, without waiting for a clock edge.
- R7: After `rst_req_n_i` rises, it is synchronized over 2 master edges. `cpu_rst_o` and `bus_rst_o` then fall on the master edge that gives the second rising edge of `cpu_clk_o`.
- R8: While `rst_req_n_i` is low, every master edge drives `cpu_clk_o`, `timer_clk_o`, `osc_half_o` and `ready_o` low and restarts the dividers at phase zero.
- R9: A processor clock edge is a master edge on which `cpu_clk_o` changes. On any such edge where `wait_n_i` is low, `ready_o` goes low on that same edge.
- R10: `ready_o` goes high only on a falling processor clock edge, and only when `wait_n_i` was high both on that edge and on the rising processor clock edge just before it. It then stays high until R9 or R8 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master oscillator clock |
| rst_req_n_i | input | 1 | Asynchronous active-low reset request |
| fast_sel_i | input | 1 | 1 selects divide-by-4, 0 selects divide-by-6 |
| wait_n_i | input | 1 | Active-low wait request |
| cpu_clk_o | output | 1 | Processor clock |
| timer_clk_o | output | 1 | Master clock divided by 24 |
| osc_half_o | output | 1 | Master clock divided by 2 |
| cpu_rst_o | output | 1 | Processor reset, active high |
| bus_rst_o | output | 1 | Bus reset, active high |
| ready_o | output | 1 | Processor READY |

## Verification
The clock outputs and READY are registers, so each one changes on the same master edge that moves the divider. The bench samples every output at the following falling edge and compares it with a model. That model updates only when it sees `cpu_clk_o` change, using the `wait_n_i` and `fast_sel_i` values that were held across the edge just passed. Reset assertion is expected without any edge, so the bench checks it 1 ns after driving the request low. Reset release is due 2 master edges after the request rises, plus two observed rising edges of `cpu_clk_o`. The bench counts those rising edges rather than a fixed number of cycles. Period lengths are counted in master cycles between observed edges. The first period after each reset is skipped, because the held-low time before it is of any length.

// File: rtl/ctg_pkg.sv
package ctg_pkg;

    typedef enum logic {
        MODE_SLOW = 1'b0,
        MODE_FAST = 1'b1
    } cpu_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } cpu_edge_t;

    localparam int SLOW_DIV     = 6;
    localparam int FAST_DIV     = 4;
    localparam int HIGH_CYC     = 2;
    localparam int TMR_DIV      = 24;
    localparam int MSYNC_STAGES = 2;
    localparam int RST_STAGES   = 2;

    function automatic int period_of(cpu_mode_e m, int slow_div, int fast_div);
        return (m == MODE_FAST) ? fast_div : slow_div;
    endfunction

endpackage

// File: rtl/ctg_rst_sync.sv
module ctg_rst_sync
    import ctg_pkg::*;
#(
    parameter int SYNC_STAGES = MSYNC_STAGES,
    parameter int OUT_STAGES  = RST_STAGES
) (
    input  logic clk_i,
    input  logic rst_req_n_i,
    input  logic cpu_rise_i,
    output logic mrst_o,
    output logic cpu_rst_o,
    output logic bus_rst_o
);

    logic [SYNC_STAGES-1:0] msync_q;
    logic [OUT_STAGES-1:0]  chain_q;

    // master-domain reset: immediate assert, release after SYNC_STAGES edges
    always_ff @(posedge clk_i or negedge rst_req_n_i) begin
        if (!rst_req_n_i) msync_q <= '1;
        else              msync_q <= {msync_q[SYNC_STAGES-2:0], 1'b0};
    end

    assign mrst_o = msync_q[SYNC_STAGES-1];

    // output reset: release counted on processor clock rising edges
    always_ff @(posedge clk_i or negedge rst_req_n_i) begin
        if (!rst_req_n_i)    chain_q <= '1;
        else if (mrst_o)     chain_q <= '1;
        else if (cpu_rise_i) chain_q <= {chain_q[OUT_STAGES-2:0], 1'b0};
    end

    assign cpu_rst_o = chain_q[OUT_STAGES-1];
    assign bus_rst_o = chain_q[OUT_STAGES-1];

    p_rst_async_r6: assert property (@(posedge clk_i)
        !rst_req_n_i |-> (cpu_rst_o && bus_rst_o && mrst_o));

    p_rst_rel_r7: assert property (@(posedge clk_i) disable iff (!rst_req_n_i)
        $fell(cpu_rst_o) |-> $past(cpu_rise_i));

endmodule

// File: rtl/ctg_cpu_div.sv
module ctg_cpu_div
    import ctg_pkg::*;
#(
    parameter int SLOW = SLOW_DIV,
    parameter int FAST = FAST_DIV,
    parameter int HIGH = HIGH_CYC
) (
    input  logic      clk_i,
    input  logic      mrst_i,
    input  logic      fast_sel_i,
    output logic      cpu_clk_o,
    output cpu_edge_t edge_o
);

    localparam int W = $clog2(SLOW);

    cpu_mode_e      mode_q;
    logic [W-1:0]   cnt_q, cnt_d, last_v, rise_pt;
    logic           clk_q, wrap;

    always_comb begin
        last_v      = W'(period_of(mode_q, SLOW, FAST) - 1);
        rise_pt     = last_v - W'(HIGH);
        wrap        = (cnt_q == last_v);
        cnt_d       = wrap ? '0 : cnt_q + 1'b1;
        edge_o.rise = !mrst_i && (cnt_q == rise_pt);
        edge_o.fall = !mrst_i && wrap;
    end

    always_ff @(posedge clk_i) begin
        if (mrst_i) begin
            cnt_q  <= '0;
            clk_q  <= 1'b0;
            mode_q <= cpu_mode_e'(fast_sel_i);
        end else begin
            cnt_q <= cnt_d;
            clk_q <= (cnt_d > rise_pt);
            if (wrap) mode_q <= cpu_mode_e'(fast_sel_i);
        end
    end

    assign cpu_clk_o = clk_q;

    p_high_len_r1: assert property (@(posedge clk_i) disable iff (mrst_i)
        $rose(clk_q) |=> clk_q ##1 !clk_q);

    p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (mrst_i)
        !wrap |=> $stable(mode_q));

endmodule

// File: rtl/ctg_aux_div.sv
module ctg_aux_div
    import ctg_pkg::*;
#(
    parameter int TDIV = TMR_DIV
) (
    input  logic clk_i,
    input  logic mrst_i,
    output logic timer_clk_o,
    output logic osc_half_o
);

    localparam int W = $clog2(TDIV);

    logic [W-1:0] tcnt_q, tcnt_d;
    logic         tclk_q, osc_q;

    always_comb begin
        tcnt_d = (tcnt_q == W'(TDIV - 1)) ? '0 : tcnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (mrst_i) begin
            tcnt_q <= '0;
            tclk_q <= 1'b0;
            osc_q  <= 1'b0;
        end else begin
            tcnt_q <= tcnt_d;
            tclk_q <= (tcnt_d >= W'(TDIV / 2));
            osc_q  <= !osc_q;
        end
    end

    assign timer_clk_o = tclk_q;
    assign osc_half_o  = osc_q;

    p_tmr_high_r4: assert property (@(posedge clk_i) disable iff (mrst_i)
        $rose(tclk_q) |=> tclk_q);

    p_osc_toggle_r5: assert property (@(posedge clk_i) disable iff (mrst_i)
        !$past(mrst_i) |-> (osc_q != $past(osc_q)));

endmodule

// File: rtl/ctg_ready_sync.sv
module ctg_ready_sync
    import ctg_pkg::*;
(
    input  logic      clk_i,
    input  logic      mrst_i,
    input  cpu_edge_t edge_i,
    input  logic      wait_n_i,
    output logic      ready_o
);

    logic seen_q, rdy_q;

    always_ff @(posedge clk_i) begin
        if (mrst_i) begin
            seen_q <= 1'b0;
            rdy_q  <= 1'b0;
        end else if (edge_i.rise) begin
            if (!wait_n_i) begin
                seen_q <= 1'b0;
                rdy_q  <= 1'b0;
            end else begin
                seen_q <= 1'b1;
            end
        end else if (edge_i.fall) begin
            if (!wait_n_i) begin
                seen_q <= 1'b0;
                rdy_q  <= 1'b0;
            end else begin
                rdy_q <= seen_q;
            end
        end
    end

    assign ready_o = rdy_q;

    p_ready_drop_r9: assert property (@(posedge clk_i) disable iff (mrst_i)
        ((edge_i.rise || edge_i.fall) && !wait_n_i) |=> !ready_o);

    p_ready_on_fall_r10: assert property (@(posedge clk_i) disable iff (mrst_i)
        $rose(ready_o) |-> $past(edge_i.fall && wait_n_i));

endmodule

// File: rtl/cpu_timing_gen.sv
module cpu_timing_gen
    import ctg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_req_n_i,
    input  logic fast_sel_i,
    input  logic wait_n_i,
    output logic cpu_clk_o,
    output logic timer_clk_o,
    output logic osc_half_o,
    output logic cpu_rst_o,
    output logic bus_rst_o,
    output logic ready_o
);

    logic      mrst;
    cpu_edge_t cpu_edge;

    ctg_rst_sync u_rst (
        .clk_i       (clk_i),
        .rst_req_n_i (rst_req_n_i),
        .cpu_rise_i  (cpu_edge.rise),
        .mrst_o      (mrst),
        .cpu_rst_o   (cpu_rst_o),
        .bus_rst_o   (bus_rst_o)
    );

    ctg_cpu_div u_cdiv (
        .clk_i      (clk_i),
        .mrst_i     (mrst),
        .fast_sel_i (fast_sel_i),
        .cpu_clk_o  (cpu_clk_o),
        .edge_o     (cpu_edge)
    );

    ctg_aux_div u_adiv (
        .clk_i       (clk_i),
        .mrst_i      (mrst),
        .timer_clk_o (timer_clk_o),
        .osc_half_o  (osc_half_o)
    );

    ctg_ready_sync u_rdy (
        .clk_i    (clk_i),
        .mrst_i   (mrst),
        .edge_i   (cpu_edge),
        .wait_n_i (wait_n_i),
        .ready_o  (ready_o)
    );

endmodule

// File: tb/cpu_timing_gen_tb.sv
`timescale 1ns/1ps
module cpu_timing_gen_tb;

    logic clk = 1'b0;
    logic rst_req_n = 1'b1;
    logic fast_sel = 1'b0;
    logic wait_n = 1'b1;
    logic cpu_clk, timer_clk, osc_half, cpu_rst, bus_rst, ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cpu_timing_gen u_dut (
        .clk_i       (clk),
        .rst_req_n_i (rst_req_n),
        .fast_sel_i  (fast_sel),
        .wait_n_i    (wait_n),
        .cpu_clk_o   (cpu_clk),
        .timer_clk_o (timer_clk),
        .osc_half_o  (osc_half),
        .cpu_rst_o   (cpu_rst),
        .bus_rst_o   (bus_rst),
        .ready_o     (ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int low_len_of(input bit fast);
        return fast ? 2 : 4;
    endfunction

    // model state
    bit prev_clk = 0, prev_tmr = 0, prev_osc = 0;
    bit skip_c = 1, skip_t = 1, m_fast = 0;
    bit r_exp = 0, s_exp = 0;
    int lo_len = 0, hi_len = 0, tlo = 0, thi = 0, rises = 0, rel_steps = 0;
    int wait_hold = 0;

    task automatic step();
        bit rst_seen, w_seen, f_seen, c_rise, c_fall;
        @(negedge clk);
        rst_seen = rst_req_n;
        w_seen   = wait_n;
        f_seen   = fast_sel;
        if (!rst_seen) begin
            chk(cpu_rst && bus_rst, "R6 reset held", int'(cpu_rst), 1);
            chk(!cpu_clk && !timer_clk && !osc_half, "R8 clocks low",
                int'({cpu_clk, timer_clk, osc_half}), 0);
            chk(!ready, "R8 ready low", int'(ready), 0);
            r_exp = 0; s_exp = 0; rises = 0; rel_steps = 0;
            skip_c = 1; skip_t = 1; lo_len = 0; tlo = 0;
        end else begin
            rel_steps++;
            c_rise = cpu_clk && !prev_clk;
            c_fall = !cpu_clk && prev_clk;
            if (c_rise) begin
                rises++;
                if (!skip_c)
                    chk(lo_len == low_len_of(m_fast), m_fast ? "R2 low time" : "R1 low time",
                        lo_len, low_len_of(m_fast));
                skip_c = 0;
                hi_len = 1;
                if (!w_seen) begin r_exp = 0; s_exp = 0; end
                else s_exp = 1;
            end else if (c_fall) begin
                chk(hi_len == 2, "R1 R2 high time", hi_len, 2);
                lo_len = 1;
                m_fast = f_seen;   // R3: mode sampled at falling edge
                if (!w_seen) begin r_exp = 0; s_exp = 0; end
                else r_exp = s_exp;
            end else begin
                if (cpu_clk) hi_len++; else lo_len++;
            end
            chk(ready == r_exp, r_exp ? "R10 ready set" : "R9 ready clear", int'(ready), int'(r_exp));
            chk(cpu_rst == (rises < 2) && bus_rst == cpu_rst, "R7 reset release",
                int'(cpu_rst), int'(rises < 2));
            // timer
            if (timer_clk && !prev_tmr) begin
                if (!skip_t) chk(tlo == 12, "R4 timer low", tlo, 12);
                skip_t = 0; thi = 1;
            end else if (!timer_clk && prev_tmr) begin
                chk(thi == 12, "R4 timer high", thi, 12);
                tlo = 1;
            end else begin
                if (timer_clk) thi++; else tlo++;
            end
            if (rel_steps >= 3)
                chk(osc_half != prev_osc, "R5 half-rate toggle", int'(osc_half), int'(!prev_osc));
        end
        prev_clk = cpu_clk; prev_tmr = timer_clk; prev_osc = osc_half;
    endtask

    task automatic drive_wait();
        if (wait_hold == 0) begin
            wait_n    = ($urandom % 3) != 0;
            wait_hold = wait_n ? 1 + int'($urandom % 24) : 1 + int'($urandom % 32);
        end
        wait_hold--;
    endtask

    task automatic pulse_reset(input int len);
        rst_req_n = 1'b0;
        #1;
        chk(cpu_rst && bus_rst, "R6 async assert", int'(cpu_rst && bus_rst), 1);
        for (int i = 0; i < len; i++) step();
        rst_req_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'hC0FFEE));
        #1 rst_req_n = 1'b0;
        for (int i = 0; i < 6; i++) step();
        rst_req_n = 1'b1;
        // directed: slow mode, wait high
        for (int i = 0; i < 120; i++) step();
        // directed: single-cycle wait pulse and a 32-cycle wait
        wait_n = 1'b0; step(); wait_n = 1'b1;
        for (int i = 0; i < 20; i++) step();
        wait_n = 1'b0;
        for (int i = 0; i < 32; i++) step();
        wait_n = 1'b1;
        for (int i = 0; i < 30; i++) step();
        // directed: fast mode
        fast_sel = 1'b1;
        for (int i = 0; i < 120; i++) step();
        // directed: reset in fast mode, async check inside
        @(negedge clk);
        pulse_reset(4);
        for (int i = 0; i < 60; i++) step();
        // random mix
        for (int i = 0; i < 20000; i++) begin
            drive_wait();
            if (($urandom % 40) == 0) fast_sel = ~fast_sel;
            if (($urandom % 3000) == 0) begin
                @(negedge clk);
                pulse_reset(2 + int'($urandom % 6));
            end
            step();
        end
        finish_run();
    end

    initial begin
        #(5 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule